// File: doc/BRIEF.md
# Host Register and Memory Access Port

This block is the byte-wide host side of a time-slot switch. A host reaches it with an active-low chip select, an active-high data strobe, a read/write line that is high for a read, and six address lines. It acknowledges each access on an active-low acknowledge. The bidirectional host data bus is presented as separate inbound and outbound byte paths plus an output enable. The enable is meant to drive a pad driver outside the block.

Addressing is paged. The top address bit chooses between an 8-bit control register and the memory window. The control register holds the memory type and the stream number. The low five address bits pick one of 32 channels inside that window. The control register also carries two global mode bits that go to the switching core:
- Split mode sends reads to the data memory and writes to the low connection memory.
- Message mode is a broadcast enable.

Memory accesses are not performed locally. The block raises a request and waits until the core reports a free slot in its memory schedule. It captures read data in that slot and only then acknowledges. Control-register writes are the only transactions that are acknowledged without delay.

The state machine has four states:
- IDLE waits for a strobe.
- WAIT_SLOT holds a memory request until a slot is free.
- SETTLE is a one-cycle completion used by control-register reads and by ignored accesses.
- ACKED holds the acknowledge low until the strobe or chip select goes inactive.

Its transitions are:
- IDLE→ACKED on a control-register write.
- IDLE→SETTLE on a control-register read or an ignored access.
- IDLE→WAIT_SLOT on a valid memory access.
- WAIT_SLOT→ACKED on a free slot.
- SETTLE→ACKED.
- Any busy state→IDLE on release, meaning chip select high or strobe low.

Top module: `host_port`

## Requirements
- R1: After reset, ack_n is 1, mem_req is 0, split_mode and msg_mode are 0, and the control register reads as 0x00.
- R2: With addr[5]=0 the control register is accessed, whatever addr[4:0] hold. A write stores the byte with bit 5 forced to 0, and a read returns the stored value.
- R3: A control-register write drives ack_n low in the first cycle after the clock edge that samples the strobe. Every other access takes at least two cycles.
- R4: split_mode equals control bit 7 and msg_mode equals control bit 6.
- R5: With addr[5]=1 and split mode off, the access goes to the memory coded in control bits 4:3, presented on mem_sel. The codes are 01 data memory, 10 low connection memory and 11 high connection memory. mem_stream carries control bits 2:0, mem_chan carries addr[4:0], mem_we is 1 for a write, and mem_wdata carries the written byte.
- R6: mem_req stays high until a cycle with slot_free=1. In that cycle read data is taken from mem_rdata, and ack_n goes low in the next cycle, with data_out holding the captured byte.
- R7: With split mode on, memory-window reads use mem_sel=01 and writes use mem_sel=10, whatever bits 4:3 hold.
- R8: A write to the data memory, or any access with select code 00, raises no mem_req and is acknowledged two cycles after it starts. A read with code 00 returns 0x00.
- R9: ack_n returns high in the cycle after chip select goes high or the strobe goes low. Releasing the strobe while a request waits for a slot withdraws the request without an acknowledge.
- R10: data_oe is 1 exactly while cs_n=0, ds=1 and rd_wr=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip select, active low |
| ds | input | 1 | Host data strobe, active high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Host address; bit 5 picks control register (0) or memory window (1) |
| data_in | input | 8 | Host write data (inbound half of the data bus) |
| data_out | output | 8 | Host read data (outbound half of the data bus) |
| data_oe | output | 1 | Drive enable for the outbound data bus |
| ack_n | output | 1 | Access complete, active low |
| split_mode | output | 1 | Global split-memory mode to the core |
| msg_mode | output | 1 | Global message-mode enable to the core |
| mem_req | output | 1 | Memory cycle request to the core |
| mem_we | output | 1 | Requested cycle is a write |
| mem_sel | output | 2 | Memory code: 01 data, 10 low connection, 11 high connection |
| mem_stream | output | 3 | Stream section of the memory |
| mem_chan | output | 5 | Channel within the stream |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read by the core in the granted slot |
| slot_free | input | 1 | Core grants the pending request this cycle |

## Verification
The properties assume a well-behaved host:
- The address, read/write and write data stay stable from the moment the strobe opens until acknowledge or release.
- A new strobe begins only after the previous one has been seen inactive for a clock.
- The core returns mem_rdata in the same cycle that it raises slot_free.

The bench keeps to these rules by having every access task drive all host lines on a falling edge and hold them until acknowledge. The release always happens on a falling edge, with one idle cycle before the next access. The modelled core derives its read byte combinationally from mem_sel, mem_stream and mem_chan, and it drives slot_free with a never, always or one-in-four pattern.

// File: rtl/host_port_pkg.sv
package host_port_pkg;
    typedef enum logic [1:0] {
        SEL_RSVD = 2'b00,
        SEL_DATA = 2'b01,
        SEL_CLO  = 2'b10,
        SEL_CHI  = 2'b11
    } mem_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_SLOT,
        ST_SETTLE,
        ST_ACKED
    } port_state_e;

    localparam int CTL_SPLIT_BIT = 7;
    localparam int CTL_MSG_BIT   = 6;
    localparam int CTL_SPARE_BIT = 5;
    localparam int CTL_SEL_LSB   = 3;
endpackage

// File: rtl/host_port_ctrl.sv
module host_port_ctrl
    import host_port_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int STREAM_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   ctrl_q,
    output logic                split_mode,
    output logic                msg_mode,
    output mem_sel_e            sel_cfg,
    output logic [STREAM_W-1:0] stream_cfg
);
    localparam logic [DATA_W-1:0] SPARE_MASK = DATA_W'(1) << CTL_SPARE_BIT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wr_data & ~SPARE_MASK;
    end

    assign split_mode = ctrl_q[CTL_SPLIT_BIT];
    assign msg_mode   = ctrl_q[CTL_MSG_BIT];
    assign sel_cfg    = mem_sel_e'(ctrl_q[CTL_SEL_LSB +: 2]);
    assign stream_cfg = ctrl_q[STREAM_W-1:0];
endmodule

// File: rtl/host_port_decode.sv
module host_port_decode
    import host_port_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_wr,
    input  logic              split_mode,
    input  mem_sel_e          sel_cfg,
    output logic              is_ctrl,
    output mem_sel_e          target,
    output logic              mem_ok,
    output logic              zero_read
);
    always_comb begin
        is_ctrl = ~addr[ADDR_W-1];
        if (split_mode)
            target = rd_wr ? SEL_DATA : SEL_CLO;
        else
            target = sel_cfg;
        mem_ok    = (target != SEL_RSVD) && !(!rd_wr && target == SEL_DATA);
        zero_read = rd_wr && (target == SEL_RSVD);
    end
endmodule

// File: rtl/host_port_fsm.sv
module host_port_fsm
    import host_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic is_ctrl,
    input  logic rd_wr,
    input  logic mem_ok,
    input  logic slot_free,
    output logic ack_n,
    output logic mem_req,
    output logic ctrl_we,
    output logic latch_acc,
    output logic slot_take
);
    port_state_e state_q, state_d;
    logic        release_evt;

    assign release_evt = ~strobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe) begin
                    if (is_ctrl && !rd_wr) state_d = ST_ACKED;
                    else if (is_ctrl)      state_d = ST_SETTLE;
                    else if (mem_ok)       state_d = ST_WAIT_SLOT;
                    else                   state_d = ST_SETTLE;
                end
            end
            ST_WAIT_SLOT: begin
                if (release_evt)    state_d = ST_IDLE;
                else if (slot_free) state_d = ST_ACKED;
            end
            ST_SETTLE: state_d = release_evt ? ST_IDLE : ST_ACKED;
            ST_ACKED:  if (release_evt) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ack_n     = (state_q != ST_ACKED);
        mem_req   = (state_q == ST_WAIT_SLOT);
        latch_acc = (state_q == ST_IDLE) && strobe;
        ctrl_we   = latch_acc && is_ctrl && !rd_wr;
        slot_take = mem_req && slot_free && !release_evt;
    end

    // R6: a pending request is held while no slot is offered
    assert_req_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !slot_free && strobe) |=> mem_req);

    // R9: release always clears the acknowledge next cycle
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        release_evt |=> ack_n);

    // R9: acknowledge only follows a cycle with the strobe held
    assert_ack_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> $past(strobe));
endmodule

// File: rtl/host_port.sv
module host_port
    import host_port_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 6,
    parameter int STREAM_W = 3,
    localparam int CHAN_W  = ADDR_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                ds,
    input  logic                rd_wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   data_in,
    output logic [DATA_W-1:0]   data_out,
    output logic                data_oe,
    output logic                ack_n,
    output logic                split_mode,
    output logic                msg_mode,
    output logic                mem_req,
    output logic                mem_we,
    output logic [1:0]          mem_sel,
    output logic [STREAM_W-1:0] mem_stream,
    output logic [CHAN_W-1:0]   mem_chan,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                slot_free
);
    logic [DATA_W-1:0]   ctrl_q;
    mem_sel_e            sel_cfg, target, acc_sel;
    logic [STREAM_W-1:0] stream_cfg;
    logic                is_ctrl, mem_ok, zero_read;
    logic                strobe, ctrl_we, latch_acc, slot_take;
    logic                acc_rd;
    logic [CHAN_W-1:0]   acc_chan;
    logic [DATA_W-1:0]   acc_wdata, rd_q;

    assign strobe = ~cs_n & ds;

    host_port_ctrl #(.DATA_W(DATA_W), .STREAM_W(STREAM_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctrl_we), .wr_data(data_in),
        .ctrl_q(ctrl_q), .split_mode(split_mode), .msg_mode(msg_mode),
        .sel_cfg(sel_cfg), .stream_cfg(stream_cfg)
    );

    host_port_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr(addr), .rd_wr(rd_wr), .split_mode(split_mode), .sel_cfg(sel_cfg),
        .is_ctrl(is_ctrl), .target(target), .mem_ok(mem_ok), .zero_read(zero_read)
    );

    host_port_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .is_ctrl(is_ctrl),
        .rd_wr(rd_wr), .mem_ok(mem_ok), .slot_free(slot_free),
        .ack_n(ack_n), .mem_req(mem_req), .ctrl_we(ctrl_we),
        .latch_acc(latch_acc), .slot_take(slot_take)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_rd    <= 1'b1;
            acc_sel   <= SEL_RSVD;
            acc_chan  <= '0;
            acc_wdata <= '0;
        end else if (latch_acc) begin
            acc_rd    <= rd_wr;
            acc_sel   <= target;
            acc_chan  <= addr[CHAN_W-1:0];
            acc_wdata <= data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= '0;
        else if (latch_acc && rd_wr && is_ctrl)
            rd_q <= ctrl_q;
        else if (latch_acc && !is_ctrl && zero_read)
            rd_q <= '0;
        else if (slot_take && acc_rd)
            rd_q <= mem_rdata;
    end

    assign data_out   = rd_q;
    assign data_oe    = strobe & rd_wr;
    assign mem_we     = ~acc_rd;
    assign mem_sel    = acc_sel;
    assign mem_stream = stream_cfg;
    assign mem_chan   = acc_chan;
    assign mem_wdata  = acc_wdata;

    // R8: no request for a data-memory write or a reserved code
    assert_no_ignored_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_sel != SEL_RSVD) && !(mem_we && mem_sel == SEL_DATA));

    // R3: a control-register write started from idle is acknowledged next cycle
    assert_fast_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !rd_wr && !addr[ADDR_W-1] && ack_n && !mem_req) |=> !ack_n);
endmodule

// File: tb/tb_host_port.sv
module tb_host_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ds = 1'b0, rd_wr = 1'b1;
    logic [5:0] addr = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out, mem_wdata, mem_rdata;
    logic       data_oe, ack_n, split_mode, msg_mode, mem_req, mem_we;
    logic [1:0] mem_sel;
    logic [2:0] mem_stream;
    logic [4:0] mem_chan;
    logic       slot_free = 1'b0;

    int total = 0, bad = 0;
    int slot_mode = 1;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    host_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds(ds), .rd_wr(rd_wr),
        .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .ack_n(ack_n), .split_mode(split_mode), .msg_mode(msg_mode),
        .mem_req(mem_req), .mem_we(mem_we), .mem_sel(mem_sel),
        .mem_stream(mem_stream), .mem_chan(mem_chan), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .slot_free(slot_free)
    );

    function automatic logic [7:0] core_byte(logic [1:0] s, logic [2:0] st, logic [4:0] ch);
        return {st, ch} ^ {s, 6'b0};
    endfunction

    assign mem_rdata = core_byte(mem_sel, mem_stream, mem_chan);

    always @(negedge clk) begin
        cyc <= cyc + 1;
        slot_free <= (slot_mode == 1) || (slot_mode == 2 && (cyc % 4) == 0);
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 waiting for slot, 2 one-cycle delay, 3 acknowledged
    int         m_phase = 0;
    logic [7:0] m_ctrl = 0, m_rd = 0, m_wd = 0;
    logic [1:0] m_sel = 0;
    logic [4:0] m_chan = 0;
    bit         m_isrd = 1;

    always @(posedge clk) begin
        bit strobe;
        strobe = !cs_n && ds;
        if (!rst_n) begin
            m_phase = 0; m_ctrl = 0; m_rd = 0;
        end else begin
            case (m_phase)
                0: if (strobe) begin
                    m_isrd = rd_wr;
                    if (!addr[5]) begin
                        if (!rd_wr) begin m_ctrl = data_in & 8'hDF; m_phase = 3; end
                        else begin m_rd = m_ctrl; m_phase = 2; end
                    end else begin
                        m_chan = addr[4:0];
                        m_wd = data_in;
                        m_sel = m_ctrl[7] ? (rd_wr ? 2'b01 : 2'b10) : m_ctrl[4:3];
                        if (m_sel == 2'b00) begin m_phase = 2; if (rd_wr) m_rd = 0; end
                        else if (m_sel == 2'b01 && !rd_wr) m_phase = 2;
                        else m_phase = 1;
                    end
                end
                1: if (!strobe) m_phase = 0;
                   else if (slot_free) begin
                       if (m_isrd) m_rd = core_byte(m_sel, m_ctrl[2:0], m_chan);
                       m_phase = 3;
                   end
                2: m_phase = strobe ? 3 : 0;
                default: if (!strobe) m_phase = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(ack_n == (m_phase != 3), "R3/R6/R9 ack_n", ack_n, m_phase != 3);
            chk(mem_req == (m_phase == 1), "R6/R8/R9 mem_req", mem_req, m_phase == 1);
            chk(split_mode == m_ctrl[7], "R4 split_mode", split_mode, m_ctrl[7]);
            chk(msg_mode == m_ctrl[6], "R4 msg_mode", msg_mode, m_ctrl[6]);
            chk(data_oe == (!cs_n && ds && rd_wr), "R10 data_oe", data_oe, !cs_n && ds && rd_wr);
            if (m_phase == 1) begin
                chk(mem_sel == m_sel, "R5/R7 mem_sel", mem_sel, m_sel);
                chk(mem_stream == m_ctrl[2:0], "R5 mem_stream", mem_stream, m_ctrl[2:0]);
                chk(mem_chan == m_chan, "R5 mem_chan", mem_chan, m_chan);
                chk(mem_we == !m_isrd, "R5 mem_we", mem_we, !m_isrd);
                if (!m_isrd) chk(mem_wdata == m_wd, "R5 mem_wdata", mem_wdata, m_wd);
            end
            if (m_phase == 3 && m_isrd)
                chk(data_out == m_rd, "R2/R6/R8 data_out", data_out, m_rd);
        end
    end

    task automatic host(input logic [5:0] a, input bit rd, input logic [7:0] wd,
                        output logic [7:0] rdat, output int lat);
        @(negedge clk);
        addr = a; rd_wr = rd; data_in = wd; cs_n = 0; ds = 1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (ack_n && lat < 60);
        rdat = data_out;
        cs_n = 1; ds = 0; rd_wr = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int lat;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(ack_n == 1 && mem_req == 0, "R1 idle outputs", {ack_n, mem_req}, 2'b10);
        chk(split_mode == 0 && msg_mode == 0, "R1 modes", {split_mode, msg_mode}, 0);
        host(6'h00, 1, 0, r, lat);
        chk(r == 8'h00, "R1 ctrl reset value", r, 0);

        // R2/R3/R4 control register, arbitrary low address bits, spare bit cleared
        host(6'h15, 0, 8'hFF, r, lat);
        chk(lat == 1, "R3 fast ctrl write latency", lat, 1);
        chk(split_mode && msg_mode, "R4 modes set", {split_mode, msg_mode}, 2'b11);
        host(6'h0A, 1, 0, r, lat);
        chk(r == 8'hDF, "R2 ctrl readback", r, 8'hDF);
        chk(lat == 2, "R3 ctrl read latency", lat, 2);
        host(6'h1F, 0, 8'h40, r, lat);
        chk(!split_mode && msg_mode, "R4 msg only", {split_mode, msg_mode}, 2'b01);

        // R5/R6 low connection memory write, stream 2, slot always free
        host(6'h00, 0, 8'h12, r, lat);
        host(6'h27, 0, 8'hA5, r, lat);
        chk(lat == 2, "R6 memory latency with free slot", lat, 2);

        // R5 high connection memory read, stream 5, channel 31
        host(6'h00, 0, 8'h1D, r, lat);
        host(6'h3F, 1, 0, r, lat);
        chk(r == core_byte(2'b11, 3'd5, 5'd31), "R5 high memory read", r, core_byte(2'b11, 3'd5, 5'd31));

        // R6 data memory read with sparse slots
        host(6'h00, 0, 8'h0B, r, lat);
        slot_mode = 0;
        repeat (2) @(negedge clk);
        slot_mode = 2;
        host(6'h24, 1, 0, r, lat);
        chk(r == core_byte(2'b01, 3'd3, 5'd4), "R6 sparse read data", r, core_byte(2'b01, 3'd3, 5'd4));
        chk(lat >= 2, "R6 latency at least two", lat, 2);
        host(6'h31, 0, 8'h3C, r, lat);
        slot_mode = 1;

        // R7 split mode overrides high-memory code
        host(6'h00, 0, 8'h99, r, lat);
        host(6'h29, 1, 0, r, lat);
        chk(r == core_byte(2'b01, 3'd1, 5'd9), "R7 split read from data memory", r, core_byte(2'b01, 3'd1, 5'd9));
        host(6'h2E, 0, 8'h5A, r, lat);
        chk(lat == 2, "R7 split write latency", lat, 2);

        // R8 ignored writes and reserved reads
        host(6'h00, 0, 8'h0B, r, lat);
        host(6'h21, 0, 8'h77, r, lat);
        chk(lat == 2, "R8 data memory write acknowledged", lat, 2);
        host(6'h00, 0, 8'h04, r, lat);
        host(6'h22, 1, 0, r, lat);
        chk(r == 8'h00 && lat == 2, "R8 reserved read", r, 0);
        host(6'h23, 0, 8'h11, r, lat);
        chk(lat == 2, "R8 reserved write acknowledged", lat, 2);

        // R9 abort while waiting for a slot
        host(6'h00, 0, 8'h12, r, lat);
        slot_mode = 0;
        @(negedge clk);
        addr = 6'h25; rd_wr = 1; cs_n = 0; ds = 1;
        repeat (3) @(negedge clk);
        chk(mem_req == 1 && ack_n == 1, "R9 waiting request", {mem_req, ack_n}, 2'b11);
        ds = 0;
        @(negedge clk);
        chk(mem_req == 0 && ack_n == 1, "R9 request withdrawn", {mem_req, ack_n}, 2'b01);
        cs_n = 1;
        slot_mode = 1;
        @(negedge clk);

        // R10 enable stays low for writes and deselected reads
        cs_n = 0; ds = 0; rd_wr = 1; addr = 6'h00;
        @(negedge clk);
        chk(data_oe == 0, "R10 no strobe", data_oe, 0);
        cs_n = 1; ds = 1;
        @(negedge clk);
        chk(data_oe == 0, "R10 deselected", data_oe, 0);
        ds = 0;
        @(negedge clk);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule